// File: doc/BRIEF.md
# Interrupt Dispatch Controller

This block gathers event requests from a set of on-chip sources and records each one in a per-source latch. It combines the recorded requests with a software-written enable mask and chooses a winner with a fixed priority rule. When the CPU's global enable flag is set and the core reports an instruction boundary, the block takes over the core for a fixed-length hardware call. During that call it emits three stack pushes, clears the flag register, and loads the program counter with the winner's table entry.

A return-from-interrupt is signalled through a small restore port. The block reloads the saved program counter and flags on the following cycle. If a request is still waiting and the restored flags enable interrupts, the next call is chained in straight away, before the core runs another instruction.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `push_vld`, `flag_wr` and `pc_ld` are low, every mask bit is 0 and no request is recorded.
- R2: Source i is recorded when `src_req[i]` rises. It stays recorded until a clear write with `clr_wdata[i]`=1 (a 1 clears, a 0 leaves the bit alone) or until it is acknowledged. If a rising edge and a clear of the same bit fall in one cycle, the bit stays recorded.
- R3: A recorded source is pending only while its mask bit (`msk_wdata[i]`, latched on `msk_we`) is 1. A masked source never causes a call. Setting the mask bit of a source that is already recorded makes it pending.
- R4: A call starts only in a cycle with `insn_done`=1, at least one pending source and `flags_cur[0]`=1 (or in the restore cycle of R10). `busy` then rises on the next cycle and stays high for exactly CALL_CYCLES (13) cycles.
- R5: In the first three busy cycles `push_vld` is high, and `push_data` carries PC[15:8], then PC[7:0], then the flags, all as they were in the starting cycle.
- R6: In the fourth busy cycle `flag_wr`=1 with value 0x00. In the last busy cycle `pc_ld`=1 with value {8'h00, vector}.
- R7: The lowest-numbered pending source wins, and its vector is 4*(index+1).
- R8: The winning source's record is cleared when its call starts, so it is not taken a second time.
- R9: `reti_req` while idle gives, on the next cycle, `flag_wr`=1 with `reti_flags` and `pc_ld`=1 with `reti_pc`. `busy` stays low in that cycle.
- R10: If, in that restore cycle, a source is pending and `reti_flags[0]`=1, a call starts without `insn_done`. It pushes the restored PC and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Source request lines |
| msk_we | input | 1 | Mask register write strobe |
| msk_wdata | input | NSRC | New mask value |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | NSRC | Clear bits, 1 clears the record |
| flags_cur | input | 8 | CPU flag register, bit 0 is the global enable |
| pc_cur | input | 16 | CPU program counter |
| insn_done | input | 1 | Instruction boundary strobe |
| reti_req | input | 1 | Return-from-interrupt strobe |
| reti_pc | input | 16 | Program counter to restore |
| reti_flags | input | 8 | Flags to restore |
| push_vld | output | 1 | Stack push strobe |
| push_data | output | 8 | Byte to push |
| flag_wr | output | 1 | Flag register write |
| flag_wr_val | output | 8 | Flag register value |
| pc_ld | output | 1 | Program counter load |
| pc_ld_val | output | 16 | Program counter value |
| busy | output | 1 | Hardware call in progress |

## Verification
A clear write can land in the same cycle as a new rising edge on the same source. This case is provoked by driving a clear of bit 3 together with a pulse on source 3. The result is judged by whether a call with vector 0x10 follows at the next boundary. A return can also fall in the same cycle as the start of a chained call. That case is judged by the restore items being followed directly by pushes of the restored PC and flags, with no boundary strobe in between.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RET  = 2'd1,
      SQ_CALL = 2'd2
   } sq_state_t;

   typedef struct packed {
      logic [15:0] pc;
      logic [7:0]  flg;
   } cpu_ctx_t;

   localparam int unsigned PC_W  = 16;
   localparam int unsigned FLG_W = 8;
endpackage

// File: rtl/irq_post_bank.sv
module irq_post_bank #(
   parameter int unsigned NSRC     = 8,
   parameter bit          SRC_EDGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_req,
   input  logic            msk_we,
   input  logic [NSRC-1:0] msk_wdata,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_wdata,
   input  logic [NSRC-1:0] ack,
   output logic [NSRC-1:0] pend
);
   logic [NSRC-1:0] evt;
   logic [NSRC-1:0] posted;
   logic [NSRC-1:0] msk_q;

   generate
      if (SRC_EDGE) begin : g_edge
         logic [NSRC-1:0] src_d;
         always_ff @(posedge clk) begin
            if (!rst_n) src_d <= '0;
            else        src_d <= src_req;
         end
         assign evt = src_req & ~src_d;
      end else begin : g_level
         assign evt = src_req;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      msk_q <= '0;
      else if (msk_we) msk_q <= msk_wdata;
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         logic rec_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                rec_q <= 1'b0;
            else if (evt[i])                           rec_q <= 1'b1;
            else if ((clr_we && clr_wdata[i]) || ack[i]) rec_q <= 1'b0;
         end
         assign posted[i] = rec_q;
      end
   endgenerate

   assign pend = posted & msk_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NSRC           = 8,
   parameter int unsigned IDXW           = 3,
   parameter int unsigned VEC_STEP       = 4,
   parameter int unsigned VW             = 8,
   parameter bit          PRIO_LOW_FIRST = 1'b1
) (
   input  logic [NSRC-1:0] pend,
   output logic            any,
   output logic [NSRC-1:0] onehot,
   output logic [VW-1:0]   vec
);
   logic [IDXW-1:0] idx;

   generate
      if (PRIO_LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
               if (pend[i]) idx = i[IDXW-1:0];
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NSRC; i++) begin
               if (pend[i]) idx = i[IDXW-1:0];
            end
         end
      end
   endgenerate

   always_comb begin
      any    = |pend;
      onehot = any ? (NSRC'(1) << idx) : '0;
      vec    = VW'((32'(idx) + 32'd1) * 32'(VEC_STEP));
   end
endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq
   import irq_pkg::*;
#(
   parameter int unsigned NSRC        = 8,
   parameter int unsigned CALL_CYCLES = 13,
   parameter int unsigned VW          = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any,
   input  logic [NSRC-1:0]   onehot,
   input  logic [VW-1:0]     vec,
   input  logic              insn_done,
   input  logic [FLG_W-1:0]  flags_cur,
   input  logic [PC_W-1:0]   pc_cur,
   input  logic              reti_req,
   input  logic [PC_W-1:0]   reti_pc,
   input  logic [FLG_W-1:0]  reti_flags,
   output logic [NSRC-1:0]   ack,
   output logic              push_vld,
   output logic [7:0]        push_data,
   output logic              flag_wr,
   output logic [FLG_W-1:0]  flag_wr_val,
   output logic              pc_ld,
   output logic [PC_W-1:0]   pc_ld_val,
   output logic              busy
);
   localparam int unsigned CNTW = $clog2(CALL_CYCLES);
   localparam logic [CNTW-1:0] SLOT_PCH  = CNTW'(0);
   localparam logic [CNTW-1:0] SLOT_PCL  = CNTW'(1);
   localparam logic [CNTW-1:0] SLOT_FLG  = CNTW'(2);
   localparam logic [CNTW-1:0] SLOT_FCLR = CNTW'(3);
   localparam logic [CNTW-1:0] SLOT_LOAD = CNTW'(CALL_CYCLES - 1);

   sq_state_t       st_q;
   logic [CNTW-1:0] cnt_q;
   cpu_ctx_t        ctx_q;
   cpu_ctx_t        ret_q;
   logic [VW-1:0]   vec_q;
   logic            go_idle;
   logic            go_ret;

   assign go_idle = (st_q == SQ_IDLE) && !reti_req && any && flags_cur[0] && insn_done;
   assign go_ret  = (st_q == SQ_RET) && any && ret_q.flg[0];
   assign ack     = (go_idle || go_ret) ? onehot : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
         ctx_q <= '0;
         ret_q <= '0;
         vec_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (reti_req) begin
                  st_q  <= SQ_RET;
                  ret_q <= '{pc: reti_pc, flg: reti_flags};
               end else if (go_idle) begin
                  st_q  <= SQ_CALL;
                  cnt_q <= '0;
                  ctx_q <= '{pc: pc_cur, flg: flags_cur};
                  vec_q <= vec;
               end
            end
            SQ_RET: begin
               if (go_ret) begin
                  st_q  <= SQ_CALL;
                  cnt_q <= '0;
                  ctx_q <= ret_q;
                  vec_q <= vec;
               end else begin
                  st_q <= SQ_IDLE;
               end
            end
            SQ_CALL: begin
               if (cnt_q == SLOT_LOAD) st_q <= SQ_IDLE;
               else                    cnt_q <= cnt_q + CNTW'(1);
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      busy        = (st_q == SQ_CALL);
      push_vld    = busy && (cnt_q <= SLOT_FLG);
      push_data   = '0;
      case (cnt_q)
         SLOT_PCH: push_data = ctx_q.pc[15:8];
         SLOT_PCL: push_data = ctx_q.pc[7:0];
         SLOT_FLG: push_data = ctx_q.flg;
         default:  push_data = '0;
      endcase
      if (!push_vld) push_data = '0;
      flag_wr     = (busy && cnt_q == SLOT_FCLR) || (st_q == SQ_RET);
      flag_wr_val = (st_q == SQ_RET) ? ret_q.flg : '0;
      pc_ld       = (busy && cnt_q == SLOT_LOAD) || (st_q == SQ_RET);
      pc_ld_val   = (st_q == SQ_RET) ? ret_q.pc : {{(PC_W - VW){1'b0}}, vec_q};
   end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl #(
   parameter int unsigned NSRC           = 8,
   parameter int unsigned VEC_STEP       = 4,
   parameter int unsigned CALL_CYCLES    = 13,
   parameter bit          SRC_EDGE       = 1'b1,
   parameter bit          PRIO_LOW_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_req,
   input  logic            msk_we,
   input  logic [NSRC-1:0] msk_wdata,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_wdata,
   input  logic [7:0]      flags_cur,
   input  logic [15:0]     pc_cur,
   input  logic            insn_done,
   input  logic            reti_req,
   input  logic [15:0]     reti_pc,
   input  logic [7:0]      reti_flags,
   output logic            push_vld,
   output logic [7:0]      push_data,
   output logic            flag_wr,
   output logic [7:0]      flag_wr_val,
   output logic            pc_ld,
   output logic [15:0]     pc_ld_val,
   output logic            busy
);
   localparam int unsigned VW   = 8;
   localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

   generate
      if (NSRC < 2) begin : g_bad_nsrc
         $error("NSRC must be at least 2");
      end
      if (NSRC * VEC_STEP > 255) begin : g_bad_vec
         $error("vector table does not fit the low PC byte");
      end
      if (CALL_CYCLES < 5) begin : g_bad_len
         $error("CALL_CYCLES must leave room for three pushes, a clear and a load");
      end
   endgenerate

   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] ack;
   logic [NSRC-1:0] onehot;
   logic [VW-1:0]   vec;
   logic            pend_any;

   irq_post_bank #(.NSRC(NSRC), .SRC_EDGE(SRC_EDGE)) u_post (
      .clk(clk), .rst_n(rst_n), .src_req(src_req),
      .msk_we(msk_we), .msk_wdata(msk_wdata),
      .clr_we(clr_we), .clr_wdata(clr_wdata),
      .ack(ack), .pend(pend)
   );

   irq_prio_pick #(.NSRC(NSRC), .IDXW(IDXW), .VEC_STEP(VEC_STEP), .VW(VW),
                   .PRIO_LOW_FIRST(PRIO_LOW_FIRST)) u_pick (
      .pend(pend), .any(pend_any), .onehot(onehot), .vec(vec)
   );

   irq_call_seq #(.NSRC(NSRC), .CALL_CYCLES(CALL_CYCLES), .VW(VW)) u_seq (
      .clk(clk), .rst_n(rst_n), .any(pend_any), .onehot(onehot), .vec(vec),
      .insn_done(insn_done), .flags_cur(flags_cur), .pc_cur(pc_cur),
      .reti_req(reti_req), .reti_pc(reti_pc), .reti_flags(reti_flags),
      .ack(ack), .push_vld(push_vld), .push_data(push_data),
      .flag_wr(flag_wr), .flag_wr_val(flag_wr_val),
      .pc_ld(pc_ld), .pc_ld_val(pc_ld_val), .busy(busy)
   );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
   parameter int unsigned CALL_CYCLES = 13
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        push_vld,
   input logic        flag_wr,
   input logic [7:0]  flag_wr_val,
   input logic        pc_ld,
   input logic [15:0] pc_ld_val,
   input logic        insn_done,
   input logic        gie_bit,
   input logic        pend_any
);
   int unsigned run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   AST_CALL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == CALL_CYCLES));                                 // R4
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(insn_done && gie_bit) || $past(flag_wr && flag_wr_val[0]))); // R4
   AST_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(pend_any));                                        // R3
   AST_FIRST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> push_vld);                                               // R5
   AST_PUSH_IN_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld |-> busy);                                                      // R5
   AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && busy) |-> (flag_wr_val == 8'h00));                           // R6
   AST_VEC_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ld && busy) |-> (pc_ld_val[15:8] == 8'h00 && pc_ld_val[7:0] != 8'h00)); // R6
   AST_LOAD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ld && busy) |=> !busy);                                              // R6
endmodule

bind irq_dispatch_ctrl irq_dispatch_chk #(.CALL_CYCLES(CALL_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .push_vld(push_vld),
   .flag_wr(flag_wr), .flag_wr_val(flag_wr_val),
   .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
   .insn_done(insn_done), .gie_bit(flags_cur[0]), .pend_any(pend_any)
);

// File: tb/irq_dispatch_ctrl_test.sv
module irq_dispatch_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 8;
   localparam int K_PUSH = 0, K_FLAG = 1, K_PC = 2;

   typedef struct {
      int          kind;
      logic [15:0] val;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0] src_req = '0;
   logic msk_we = 1'b0, clr_we = 1'b0, insn_done = 1'b0, reti_req = 1'b0;
   logic [NSRC-1:0] msk_wdata = '0, clr_wdata = '0;
   logic [15:0] reti_pc = '0;
   logic [7:0]  reti_flags = '0;
   logic sw_f_we = 1'b0;
   logic [7:0] sw_f_val = '0;
   logic [7:0] cpu_f;
   logic [15:0] cpu_pc;
   logic push_vld, flag_wr, pc_ld, busy;
   logic [7:0] push_data, flag_wr_val;
   logic [15:0] pc_ld_val;

   int total = 0, bad = 0, run = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_dispatch_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req),
      .msk_we(msk_we), .msk_wdata(msk_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
      .flags_cur(cpu_f), .pc_cur(cpu_pc), .insn_done(insn_done),
      .reti_req(reti_req), .reti_pc(reti_pc), .reti_flags(reti_flags),
      .push_vld(push_vld), .push_data(push_data), .flag_wr(flag_wr),
      .flag_wr_val(flag_wr_val), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val), .busy(busy)
   );

   // minimal CPU model: flag register and program counter
   always @(posedge clk) begin
      if (!rst_n) begin
         cpu_f  <= 8'h00;
         cpu_pc <= 16'h1234;
      end else begin
         if (flag_wr)      cpu_f <= flag_wr_val;
         else if (sw_f_we) cpu_f <= sw_f_val;
         if (pc_ld)        cpu_pc <= pc_ld_val;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic take(input int kind, input logic [15:0] val);
      exp_t e;
      if (q.size() == 0) begin
         chk(1'b0, $sformatf("R3 unexpected output kind %0d", kind), val, 0);
      end else begin
         e = q.pop_front();
         chk(e.kind == kind && e.val == val, $sformatf("%s kind %0d", e.tag, e.kind), val, e.val);
      end
   endtask

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) run++;
         else if (run != 0) begin
            chk(run == 13, "R4 call length", run, 13);
            run = 0;
         end
         if (push_vld) take(K_PUSH, {8'h00, push_data});
         if (flag_wr)  take(K_FLAG, {8'h00, flag_wr_val});
         if (pc_ld)    take(K_PC, pc_ld_val);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(input int kind, input logic [15:0] val, input string tag);
      exp_t e;
      e.kind = kind; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic expect_call(input logic [15:0] pc, input logic [7:0] f,
                              input logic [7:0] vec, input string tag);
      push_exp(K_PUSH, {8'h00, pc[15:8]}, {tag, " R5 pch"});
      push_exp(K_PUSH, {8'h00, pc[7:0]},  {tag, " R5 pcl"});
      push_exp(K_PUSH, {8'h00, f},        {tag, " R5 flags"});
      push_exp(K_FLAG, 16'h0000,          {tag, " R6 flag clear"});
      push_exp(K_PC,   {8'h00, vec},      {tag, " R6 vector"});
   endtask

   task automatic pulse_src(input int i);
      src_req[i] = 1'b1; tick(1); src_req[i] = 1'b0;
   endtask

   task automatic write_mask(input logic [NSRC-1:0] v);
      msk_we = 1'b1; msk_wdata = v; tick(1); msk_we = 1'b0;
   endtask

   task automatic set_flags(input logic [7:0] v);
      sw_f_we = 1'b1; sw_f_val = v; tick(1); sw_f_we = 1'b0;
   endtask

   task automatic boundary();
      insn_done = 1'b1; tick(1); insn_done = 1'b0;
   endtask

   task automatic do_reti(input logic [15:0] pc, input logic [7:0] f, input string tag);
      push_exp(K_FLAG, {8'h00, f}, {tag, " R9 flags"});
      push_exp(K_PC, pc, {tag, " R9 pc"});
      reti_req = 1'b1; reti_pc = pc; reti_flags = f;
      tick(1);
      reti_req = 1'b0;
      chk(busy == 1'b0, {tag, " R9 busy low in restore"}, busy, 0);
   endtask

   task automatic settle(input string tag);
      tick(18);
      chk(q.size() == 0, {tag, " items left"}, q.size(), 0);
      chk(busy == 1'b0, {tag, " idle"}, busy, 0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(busy == 0, "R1 busy", busy, 0);
      chk(push_vld == 0 && flag_wr == 0 && pc_ld == 0, "R1 outputs", {push_vld, flag_wr, pc_ld}, 0);

      // masked request with enable on: nothing happens
      set_flags(8'h01);
      pulse_src(2);
      boundary(); tick(1); boundary(); tick(1); boundary();
      settle("R3 masked");

      // unmasking a recorded source makes it pending
      expect_call(16'h1234, 8'h01, 8'h0C, "R3 unmask");
      write_mask(8'h04);
      boundary();
      settle("R5 first call");
      chk(cpu_pc == 16'h000C, "R6 pc after call", cpu_pc, 16'h000C);
      chk(cpu_f == 8'h00, "R6 flags after call", cpu_f, 0);

      // return; the acknowledged record must not fire again
      do_reti(16'h1234, 8'h01, "R8 ret");
      tick(2); boundary(); tick(1); boundary();
      settle("R8 no repeat");

      // priority and chained call after return
      set_flags(8'h00);
      write_mask(8'h22);
      pulse_src(5);
      pulse_src(1);
      set_flags(8'h01);
      tick(4);
      chk(busy == 0, "R4 waits for boundary", busy, 0);
      expect_call(16'h1234, 8'h01, 8'h08, "R7 prio");
      boundary();
      settle("R7 prio");
      do_reti(16'h2000, 8'h01, "R10 chain");
      expect_call(16'h2000, 8'h01, 8'h18, "R10 chain");
      settle("R10 chain");
      chk(cpu_pc == 16'h0018, "R10 pc", cpu_pc, 16'h0018);

      // clear write removes a record
      write_mask(8'h08);
      pulse_src(3);
      clr_we = 1'b1; clr_wdata = 8'h08; tick(1); clr_we = 1'b0;
      set_flags(8'h01);
      boundary();
      settle("R2 cleared");

      // rising edge and clear in the same cycle: edge wins
      src_req[3] = 1'b1; clr_we = 1'b1; clr_wdata = 8'h08;
      tick(1);
      src_req[3] = 1'b0; clr_we = 1'b0;
      expect_call(16'h0018, 8'h01, 8'h10, "R2 edge wins");
      boundary();
      settle("R2 edge wins");

      // enable flag off blocks the call
      write_mask(8'h01);
      pulse_src(0);
      boundary(); tick(1); boundary();
      tick(4);
      chk(busy == 0, "R4 enable off", busy, 0);
      set_flags(8'h01);
      expect_call(16'h0010, 8'h01, 8'h04, "R4 enable on");
      boundary();
      settle("R4 enable on");
      chk(cpu_pc == 16'h0004, "R7 lowest vector", cpu_pc, 16'h0004);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R4 watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule